// File: doc/BRIEF.md
# Flag-Steered Two-Sided Plane Rotator

This block is the off-diagonal processing element of a parallel Jacobi eigenvalue array. It holds a 2x2 sub-block of the matrix. It receives two streams of CORDIC direction bits, one from the diagonal element that shares its row and one from the diagonal element that shares its column. It carries no angle: each received bit picks add or subtract in the shift-add rotators, so the element repeats the rotation its neighbours worked out, on both sides of its sub-block.

After `start`, the element runs one micro-rotation per iteration. Each iteration waits for one bit from each stream. The row bit rotates the two column vectors from the left, and the column bit then rotates the two row vectors from the right. When the last iteration is done, one multiply by the inverse squared gain brings the values back to scale. The four results are then rounded, saturated and presented with a one-cycle `done` strobe, ready to be exchanged with neighbouring elements.

Top module: `flag_rotor`

## Requirements
- R1: After reset the four result outputs are zero, `done` is low and the element is idle.
- R2: `start` while idle loads the four inputs, sign-extended to W+3 internal bits. `start` while a rotation is in progress has no effect on its result.
- R3: Iteration i uses shift i. The row bit r acts on each column (p, q) = (upper, lower): r=1 gives p-(q>>>i), q+(p>>>i), and r=0 gives p+(q>>>i), q-(p>>>i). The column bit c then acts on each row (p, q) = (left, right) of that result with the same rule. Bit i of a flag sequence is the flag for iteration i.
- R4: An iteration advances only once both streams have supplied their flag for it. The two flags may arrive in different cycles, and a flag that arrives first is held until its partner arrives.
- R5: A second flag on a stream whose flag for the current iteration is already held is ignored.
- R6: After ITERS iterations each element is multiplied by KSQ = round(2^FRAC / prod_{i<ITERS}(1+2^-2i)) and rounded half up at bit FRAC.
- R7: Each corrected result saturates to the signed W-bit range.
- R8: `done` is high for exactly one cycle, the cycle after the last iteration. In that cycle the outputs take their new values, and they hold them until the next completion.
- R9: Flag strobes that arrive while the element is idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load sub-block and begin a rotation |
| in_a11 | input | W | Upper-left element, signed |
| in_a12 | input | W | Upper-right element, signed |
| in_a21 | input | W | Lower-left element, signed |
| in_a22 | input | W | Lower-right element, signed |
| row_vld | input | 1 | Row-flag strobe |
| row_dir | input | 1 | Row direction flag |
| col_vld | input | 1 | Column-flag strobe |
| col_dir | input | 1 | Column direction flag |
| out_a11 | output | W | Rotated upper-left element |
| out_a12 | output | W | Rotated upper-right element |
| out_a21 | output | W | Rotated lower-left element |
| out_a22 | output | W | Rotated lower-right element |
| done | output | 1 | One-cycle result strobe |

## Verification
The bench builds the element with W=16, ITERS=12 and FRAC=24. This keeps a full 45-degree two-sided swing of full-scale entries inside the internal guard bits while the final result overflows 16 bits, so saturation is reached with ordinary vectors. The narrow width also lets a 64-bit integer reference model reproduce every shift and the gain multiply exactly. The short iteration count allows each vector to be fed under different arrival skews between the two streams: both flags in the same cycle, row first, column first with idle gaps, and a redundant row flag while the column flag is late.

// File: rtl/flag_rotor.sv
module flag_rotor #(
  parameter int W     = 32,
  parameter int ITERS = 32,
  parameter int FRAC  = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] in_a11,
  input  logic [W-1:0] in_a12,
  input  logic [W-1:0] in_a21,
  input  logic [W-1:0] in_a22,
  input  logic         row_vld,
  input  logic         row_dir,
  input  logic         col_vld,
  input  logic         col_dir,
  output logic [W-1:0] out_a11,
  output logic [W-1:0] out_a12,
  output logic [W-1:0] out_a21,
  output logic [W-1:0] out_a22,
  output logic         done
);
  localparam int IW = W + 3;
  localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam int PW = IW + FRAC + 2;

  function automatic real gain_sq(input int n);
    real g;
    g = 1.0;
    for (int i = 0; i < n; i++) g = g * (1.0 + 2.0 ** (-2 * i));
    return g;
  endfunction

  localparam int KSQ_I = $rtoi((2.0 ** FRAC) / gain_sq(ITERS) + 0.5);
  localparam logic signed [PW-1:0] KSQ  = PW'(KSQ_I);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
  localparam logic signed [PW-1:0] MAXV = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};

  typedef enum logic [1:0] {IDLE, SPIN, CORR} st_t;
  st_t st;

  logic [CW-1:0]        idx;
  logic signed [IW-1:0] x11, x12, x21, x22;
  logic                 row_hv, row_held, col_hv, col_held;

  function automatic logic signed [IW-1:0] mv_lo(input logic signed [IW-1:0] p, q,
                                                 input logic d, input logic [CW-1:0] s);
    return d ? p - (q >>> s) : p + (q >>> s);
  endfunction

  function automatic logic signed [IW-1:0] mv_hi(input logic signed [IW-1:0] p, q,
                                                 input logic d, input logic [CW-1:0] s);
    return d ? q + (p >>> s) : q - (p >>> s);
  endfunction

  function automatic logic [W-1:0] corr(input logic signed [IW-1:0] x);
    logic signed [PW-1:0] p, r;
    p = PW'(x) * KSQ;
    r = (p + HALF) >>> FRAC;
    if (r > MAXV) r = MAXV;
    if (r < MINV) r = MINV;
    return r[W-1:0];
  endfunction

  wire r_ok = row_hv | row_vld;
  wire c_ok = col_hv | col_vld;
  wire rd   = row_hv ? row_held : row_dir;
  wire cd   = col_hv ? col_held : col_dir;
  wire step = (st == SPIN) && r_ok && c_ok;

  wire signed [IW-1:0] l11 = mv_lo(x11, x21, rd, idx);
  wire signed [IW-1:0] l21 = mv_hi(x11, x21, rd, idx);
  wire signed [IW-1:0] l12 = mv_lo(x12, x22, rd, idx);
  wire signed [IW-1:0] l22 = mv_hi(x12, x22, rd, idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      idx <= '0;
      {x11, x12, x21, x22} <= '0;
      {row_hv, row_held, col_hv, col_held} <= '0;
      {out_a11, out_a12, out_a21, out_a22} <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: begin
          row_hv <= 1'b0;
          col_hv <= 1'b0;
          if (start) begin
            x11 <= IW'($signed(in_a11));
            x12 <= IW'($signed(in_a12));
            x21 <= IW'($signed(in_a21));
            x22 <= IW'($signed(in_a22));
            idx <= '0;
            st  <= SPIN;
          end
        end
        SPIN: begin
          if (step) begin
            x11 <= mv_lo(l11, l12, cd, idx);
            x12 <= mv_hi(l11, l12, cd, idx);
            x21 <= mv_lo(l21, l22, cd, idx);
            x22 <= mv_hi(l21, l22, cd, idx);
            row_hv <= 1'b0;
            col_hv <= 1'b0;
            idx <= idx + 1'b1;
            if (idx == CW'(ITERS - 1)) st <= CORR;
          end else begin
            if (row_vld && !row_hv) begin
              row_hv <= 1'b1;
              row_held <= row_dir;
            end
            if (col_vld && !col_hv) begin
              col_hv <= 1'b1;
              col_held <= col_dir;
            end
          end
        end
        default: begin
          out_a11 <= corr(x11);
          out_a12 <= corr(x12);
          out_a21 <= corr(x21);
          out_a22 <= corr(x22);
          done <= 1'b1;
          st <= IDLE;
        end
      endcase
    end
  end

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && start) |=> (st == SPIN && idx == '0));

  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SPIN && !(r_ok && c_ok)) |=> ($stable(idx) && $stable(x11) && $stable(x22)));

  assert_after_corr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st) == CORR);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(out_a11) && $stable(out_a12) && $stable(out_a21) && $stable(out_a22)));
endmodule

// File: tb/flag_rotor_bench.sv
module flag_rotor_bench;
  localparam int W = 16, N = 12, FR = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, row_vld, row_dir, col_vld, col_dir;
  logic [W-1:0] in_a11, in_a12, in_a21, in_a22;
  logic [W-1:0] out_a11, out_a12, out_a21, out_a22;
  logic done;

  flag_rotor #(.W(W), .ITERS(N), .FRAC(FR)) u_flag_rotor (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_a11(in_a11), .in_a12(in_a12), .in_a21(in_a21), .in_a22(in_a22),
    .row_vld(row_vld), .row_dir(row_dir), .col_vld(col_vld), .col_dir(col_dir),
    .out_a11(out_a11), .out_a12(out_a12), .out_a21(out_a21), .out_a22(out_a22),
    .done(done));

  typedef struct packed {
    logic signed [W-1:0] a11, a12, a21, a22;
    logic [N-1:0] rf, cf;
    logic [1:0] mode;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS[NV] = '{
    '{16'sd1000,   16'sd200,    16'sd200,    -16'sd500,   12'h5a3, 12'h0f1, 2'd0},
    '{-16'sd3000,  16'sd1234,   16'sd1234,   16'sd2500,   12'hfff, 12'h000, 2'd1},
    '{16'sd12000,  -16'sd7000,  16'sd9000,   16'sd100,    12'h3c6, 12'h9b2, 2'd2},
    '{16'sd32767,  16'sd32767,  16'sd32767,  16'sd32767,  12'haaa, 12'haaa, 2'd3},
    '{-16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768, 12'haaa, 12'haaa, 2'd0},
    '{16'sd1,      -16'sd1,     16'sd0,      16'sd3,      12'h123, 12'hedc, 2'd3},
    '{-16'sd20000, 16'sd15000,  16'sd5,      16'sd30000,  12'h777, 12'h888, 2'd1}
  };

  int n_chk = 0, n_fail = 0;
  longint ksq;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sat_corr(input longint x);
    longint r;
    r = (x * ksq + (longint'(1) <<< (FR - 1))) >>> FR;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic longint rl(input longint p, q, input logic d, input int s);
    return d ? p - (q >>> s) : p + (q >>> s);
  endfunction
  function automatic longint rh(input longint p, q, input logic d, input int s);
    return d ? q + (p >>> s) : q - (p >>> s);
  endfunction

  task automatic model(input vec_t v, output longint e11, e12, e21, e22);
    longint x11, x12, x21, x22, l11, l12, l21, l22;
    x11 = v.a11; x12 = v.a12; x21 = v.a21; x22 = v.a22;
    for (int i = 0; i < N; i++) begin
      l11 = rl(x11, x21, v.rf[i], i); l21 = rh(x11, x21, v.rf[i], i);
      l12 = rl(x12, x22, v.rf[i], i); l22 = rh(x12, x22, v.rf[i], i);
      x11 = rl(l11, l12, v.cf[i], i); x12 = rh(l11, l12, v.cf[i], i);
      x21 = rl(l21, l22, v.cf[i], i); x22 = rh(l21, l22, v.cf[i], i);
    end
    e11 = sat_corr(x11); e12 = sat_corr(x12); e21 = sat_corr(x21); e22 = sat_corr(x22);
  endtask

  task automatic idle_in;
    start = 0; row_vld = 0; col_vld = 0; row_dir = 0; col_dir = 0;
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    in_a11 = v.a11; in_a12 = v.a12; in_a21 = v.a21; in_a22 = v.a22;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic feed(input vec_t v, input bit poke_start);
    for (int i = 0; i < N; i++) begin
      case (v.mode)
        2'd0: begin
          row_vld = 1; row_dir = v.rf[i]; col_vld = 1; col_dir = v.cf[i];
          @(negedge clk); idle_in();
        end
        2'd1: begin
          row_vld = 1; row_dir = v.rf[i];
          @(negedge clk); idle_in();
          col_vld = 1; col_dir = v.cf[i];
          @(negedge clk); idle_in();
        end
        2'd2: begin
          col_vld = 1; col_dir = v.cf[i];
          @(negedge clk); idle_in();
          @(negedge clk);
          row_vld = 1; row_dir = v.rf[i];
          @(negedge clk); idle_in();
        end
        default: begin
          row_vld = 1; row_dir = v.rf[i];
          @(negedge clk);
          row_dir = ~v.rf[i];
          if (poke_start) begin
            start = 1;
            in_a11 = 16'sd777; in_a12 = -16'sd777; in_a21 = 16'sd5; in_a22 = 16'sd9;
          end
          @(negedge clk); idle_in();
          col_vld = 1; col_dir = v.cf[i];
          @(negedge clk); idle_in();
        end
      endcase
    end
  endtask

  task automatic collect(input vec_t v, input string req);
    longint e11, e12, e21, e22;
    int waited;
    model(v, e11, e12, e21, e22);
    waited = 0;
    while (!done && waited < 50) begin
      @(negedge clk);
      waited++;
    end
    chk({req, " done seen (R8)"}, done, 1);
    chk({req, " a11 (R3 R6)"}, longint'($signed(out_a11)), e11);
    chk({req, " a12 (R3 R6)"}, longint'($signed(out_a12)), e12);
    chk({req, " a21 (R3 R6)"}, longint'($signed(out_a21)), e21);
    chk({req, " a22 (R3 R6)"}, longint'($signed(out_a22)), e22);
    @(negedge clk);
    chk({req, " done one cycle R8"}, done, 0);
    repeat (3) @(negedge clk);
    chk({req, " outputs hold R8"}, longint'($signed(out_a11)), e11);
  endtask

  initial begin
    real g;
    g = 1.0;
    for (int i = 0; i < N; i++) g = g * (1.0 + 2.0 ** (-2 * i));
    ksq = $rtoi((2.0 ** FR) / g + 0.5);

    rst_n = 0; idle_in();
    in_a11 = 0; in_a12 = 0; in_a21 = 0; in_a22 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 a11", out_a11, 0); chk("R1 a12", out_a12, 0);
    chk("R1 a21", out_a21, 0); chk("R1 a22", out_a22, 0);
    chk("R1 done", done, 0);

    // Table walk: R3 R4 R5 R6 R7 under differing arrival skews
    for (int k = 0; k < NV; k++) begin
      launch(VECS[k]);
      feed(VECS[k], 1'b0);
      collect(VECS[k], $sformatf("vec%0d", k));
    end

    // R7: full-scale swing must clip
    begin
      longint e11, e12, e21, e22;
      model(VECS[3], e11, e12, e21, e22);
      chk("R7 clip positive", e11, 32767);
      model(VECS[4], e11, e12, e21, e22);
      chk("R7 clip negative", e11, -32768);
    end

    // R9: strobes while idle are ignored
    @(negedge clk);
    row_vld = 1; row_dir = 1; col_vld = 1; col_dir = 1;
    @(negedge clk); idle_in();
    row_vld = 1; row_dir = 0;
    @(negedge clk); idle_in();
    launch(VECS[0]);
    feed(VECS[0], 1'b0);
    collect(VECS[0], "R9 idle flags");

    // R2: start during rotation ignored (R5 extra row flag also present)
    launch(VECS[5]);
    feed(VECS[5], 1'b1);
    collect(VECS[5], "R2 start while busy");

    // R4: no progress without column flag
    launch(VECS[1]);
    for (int i = 0; i < N; i++) begin
      row_vld = 1; row_dir = VECS[1].rf[i];
      @(negedge clk);
    end
    idle_in();
    repeat (10) @(negedge clk);
    chk("R4 stalled no done", done, 0);
    for (int i = 0; i < N; i++) begin
      if (i > 0) begin row_vld = 1; row_dir = VECS[1].rf[i]; end
      col_vld = 1; col_dir = VECS[1].cf[i];
      @(negedge clk); idle_in();
    end
    collect(VECS[1], "R4 row early");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule